// File: doc/BRIEF.md
# Peripheral Bus Access Latch

This block sits between a CPU load/store port and a slow peripheral bus. It allows one outstanding write at a time. A store that reaches an idle bus is packed into a 32-bit latch and passed to the bus. The bus then counts as busy for a fixed number of cycles. A second store that arrives during that window is thrown away.

A load that arrives while a write is still pending never reaches the bus. It cuts the pending write short and answers at once from the latch, with the data aligned to the width of the load. To account for the time it skipped, it holds the CPU in a stall for exactly as many cycles as the cancelled write still had left. One address is set aside as a debug port: byte stores to it always reach the bus, even when the latch is occupied.

Accesses come in four widths: byte, halfword, word and doubleword. The regions behind the bus are outside this block. It only decides, cycle by cycle, whether an access goes to the bus or is answered from the latch.

Top module: `pbus_latch`

## Requirements
- R1: After reset, `busy`, `stall` and `lat_hit` are 0 and `latch_q` is 0.
- R2: A store (`req_valid`=1, `req_write`=1) issued while `busy`=0 is forwarded (`bus_fwd`=1). From the next cycle, `busy` is high for exactly DONE_CYCLES cycles (default 100) and then drops.
- R3: A store issued while `busy`=1 to any address other than the debug port is dropped: `bus_fwd`=0, `latch_q` is unchanged and the busy window is not extended.
- R4: Packing of an accepted store into `latch_q`, where `req_size` is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. A byte `req_wdata[7:0]` goes to bits 31:24 when `req_addr[0]`=0 and to bits 23:16 when `req_addr[0]`=1. A halfword `req_wdata[15:0]` goes to bits 31:16. A word `req_wdata[31:0]` fills the whole latch. A doubleword keeps only `req_wdata[63:32]`. All latch bits not written are 0.
- R5: A load issued while `busy`=1 is not forwarded. It raises `lat_hit` in the same cycle and presents `lat_rdata` as follows: a byte returns latch[31:24] in bits 7:0; a halfword returns latch[31:16] in bits 15:0; a word returns the latch in bits 31:0; a doubleword returns the latch in bits 63:32 with zeros in bits 31:0. All other bits are 0. `busy` is 0 on the next cycle.
- R6: A load that hits in the k-th busy cycle (k counted from 1) raises `stall` from the next cycle for exactly DONE_CYCLES-k+1 cycles.
- R7: A byte store to DEBUG_ADDR (default 0x05000020) is forwarded even while `busy`=1. When that happens, `latch_q` is unchanged.
- R8: When the busy window expires, `busy` clears and `latch_q` keeps its value.
- R9: A load issued while `busy`=0 is forwarded, with `lat_hit`=0 and `lat_rdata`=0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | 32 | Access address |
| req_wdata | input | 64 | Store data, right-aligned |
| bus_fwd | output | 1 | The access goes to the peripheral bus this cycle |
| busy | output | 1 | A store is outstanding |
| stall | output | 1 | CPU stall after a cancelled store |
| lat_hit | output | 1 | The load is answered from the latch this cycle |
| lat_rdata | output | 64 | Load data taken from the latch, aligned to the load width |
| latch_q | output | 32 | Current latch contents presented to the bus |

## Verification
A remaining-cycle counter that is off by one shows up as a busy window of 99 or 101 cycles. It also shows up as a stall that is one cycle too long or too short after a cancelling load. Both are visible within roughly a hundred cycles of the store. A wrong packing or unpacking lane shows on `latch_q` one cycle after the store, or on `lat_rdata` in the very cycle of the colliding load. A wrong drop decision shows at once on `bus_fwd`, and on the next cycle as a changed `latch_q`. The tests place cancelling loads at the first, a middle and the last busy cycle, because those three points expose a counter that is skewed at either end.

// File: rtl/pbus_latch.sv
module pbus_latch #(
  parameter int          DONE_CYCLES = 100,
  parameter logic [31:0] DEBUG_ADDR  = 32'h0500_0020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [63:0] req_wdata,
  output logic        bus_fwd,
  output logic        busy,
  output logic        stall,
  output logic        lat_hit,
  output logic [63:0] lat_rdata,
  output logic [31:0] latch_q
);
  localparam int TW = $clog2(DONE_CYCLES + 1);

  logic [TW-1:0] timer_q, stall_q;
  logic [31:0]   latch_r, packed_w;

  wire wr_req   = req_valid & req_write;
  wire rd_req   = req_valid & ~req_write;
  wire accept   = wr_req & ~busy;
  wire cancel   = rd_req & busy;
  wire dbg_pass = wr_req & (req_size == 2'd0) & (req_addr == DEBUG_ADDR);

  assign busy    = timer_q != '0;
  assign stall   = stall_q != '0;
  assign lat_hit = cancel;
  assign bus_fwd = req_valid & (~busy | dbg_pass);
  assign latch_q = latch_r;

  always_comb begin
    case (req_size)
      2'd0:    packed_w = req_addr[0] ? {8'h0, req_wdata[7:0], 16'h0} : {req_wdata[7:0], 24'h0};
      2'd1:    packed_w = {req_wdata[15:0], 16'h0};
      2'd2:    packed_w = req_wdata[31:0];
      default: packed_w = req_wdata[63:32];
    endcase
  end

  always_comb begin
    lat_rdata = '0;
    if (cancel) begin
      case (req_size)
        2'd0:    lat_rdata = {56'h0, latch_r[31:24]};
        2'd1:    lat_rdata = {48'h0, latch_r[31:16]};
        2'd2:    lat_rdata = {32'h0, latch_r};
        default: lat_rdata = {latch_r, 32'h0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
      latch_r <= '0;
    end else if (accept) begin
      timer_q <= TW'(DONE_CYCLES);
      latch_r <= packed_w;
    end else if (cancel) begin
      timer_q <= '0;
    end else if (busy) begin
      timer_q <= timer_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       stall_q <= '0;
    else if (cancel)  stall_q <= timer_q;
    else if (stall)   stall_q <= stall_q - 1'b1;
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r3_drop_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy) |=> $stable(latch_q));
  a_r3_drop_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy && !dbg_pass) |-> !bus_fwd);
  a_r5_hit_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hit |=> !busy);
  a_r5_hit_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hit |-> !bus_fwd);
  a_r6_stall_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cancel) |=> (stall_q == $past(stall_q) - 1'b1));
  a_r8_expiry_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q == TW'(1) && !req_valid) |=> (!busy && $stable(latch_q)));
  a_r9_idle_read_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |-> (bus_fwd && !lat_hit));
endmodule

// File: tb/pbus_latch_tb.sv
`timescale 1ns/1ps
module pbus_latch_tb;
  localparam int N = 100;
  localparam logic [31:0] DBG = 32'h0500_0020;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic bus_fwd, busy, stall, lat_hit;
  logic [63:0] lat_rdata;
  logic [31:0] latch_q;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pbus_latch #(.DONE_CYCLES(N), .DEBUG_ADDR(DBG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_fwd(bus_fwd), .busy(busy), .stall(stall), .lat_hit(lat_hit),
    .lat_rdata(lat_rdata), .latch_q(latch_q));

  task automatic check(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic issue(logic wr, logic [1:0] sz, logic [31:0] a, logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
    #1;
  endtask

  task automatic drain();
    idle();
    while (busy || stall) idle();
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 stall", stall, 0);
    check("R1 lat_hit", lat_hit, 0);
    check("R1 latch", latch_q, 0);
  endtask

  task automatic t_window();
    int cnt = 0;
    issue(1, 2'd2, 32'h1000_0000, 64'hCAFE_F00D);
    check("R2 forwarded", bus_fwd, 1);
    idle();
    while (busy && cnt < 1000) begin cnt++; idle(); end
    check("R2 busy length", cnt, N);
    check("R8 latch kept after expiry", latch_q, 32'hCAFE_F00D);
    check("R8 busy cleared", busy, 0);
  endtask

  task automatic t_pack(logic [1:0] sz, logic [31:0] a, logic [63:0] d, logic [31:0] exp, string nm);
    issue(1, sz, a, d);
    idle();
    check(nm, latch_q, exp);
    drain();
  endtask

  task automatic t_drop();
    issue(1, 2'd2, 32'h1000_0000, 64'h1111_2222);
    idle();
    issue(1, 2'd2, 32'h1000_0004, 64'h3333_4444);
    check("R3 dropped not forwarded", bus_fwd, 0);
    idle();
    check("R3 latch unchanged", latch_q, 32'h1111_2222);
    issue(0, 2'd2, 32'h1000_0000, 0);
    check("R3 read after drop", lat_rdata, 64'h1111_2222);
    drain();
  endtask

  task automatic t_hit(logic [1:0] sz, logic [63:0] exp, string nm);
    int cnt = 0;
    issue(1, 2'd2, 32'h1000_0000, 64'hA1B2_C3D4);
    issue(0, sz, 32'h1000_0000, 0);
    check({"R5 hit ", nm}, lat_hit, 1);
    check({"R5 not fwd ", nm}, bus_fwd, 0);
    check({"R5 data ", nm}, lat_rdata, exp);
    idle();
    check({"R5 busy cleared ", nm}, busy, 0);
    while (stall && cnt < 1000) begin cnt++; idle(); end
    check({"R6 stall k=1 ", nm}, cnt, N);
    drain();
  endtask

  task automatic t_stall(int k);
    int cnt = 0;
    issue(1, 2'd2, 32'h1000_0000, 64'h0);
    for (int i = 1; i < k; i++) idle();
    issue(0, 2'd2, 32'h1000_0000, 0);
    check("R6 hit at k", lat_hit, 1);
    idle();
    while (stall && cnt < 1000) begin cnt++; idle(); end
    check($sformatf("R6 stall length k=%0d", k), cnt, N - k + 1);
    drain();
  endtask

  task automatic t_debug();
    issue(1, 2'd2, 32'h1000_0000, 64'h7777_8888);
    issue(1, 2'd0, DBG, 64'h41);
    check("R7 debug forwarded while busy", bus_fwd, 1);
    idle();
    check("R7 latch unchanged", latch_q, 32'h7777_8888);
    check("R7 still busy", busy, 1);
    drain();
  endtask

  task automatic t_idle_read();
    issue(0, 2'd2, 32'h1000_0000, 0);
    check("R9 idle read forwarded", bus_fwd, 1);
    check("R9 no hit", lat_hit, 0);
    check("R9 data zero", lat_rdata, 0);
    idle();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_window();
    t_pack(2'd0, 32'h1000_0000, 64'h5A, 32'h5A00_0000, "R4 byte even");
    t_pack(2'd0, 32'h1000_0001, 64'h5A, 32'h005A_0000, "R4 byte odd");
    t_pack(2'd1, 32'h1000_0000, 64'hBEEF, 32'hBEEF_0000, "R4 half");
    t_pack(2'd3, 32'h1000_0000, 64'h1122_3344_5566_7788, 32'h1122_3344, "R4 dword");
    t_drop();
    t_hit(2'd0, 64'hA1, "byte");
    t_hit(2'd1, 64'hA1B2, "half");
    t_hit(2'd2, 64'hA1B2_C3D4, "word");
    t_hit(2'd3, 64'hA1B2_C3D4_0000_0000, "dword");
    t_stall(50);
    t_stall(N);
    t_debug();
    t_idle_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule